// File: doc/BRIEF.md
# Per-Wavefront Scalar Load Wait Gate

This block keeps a small outstanding-load counter for every wavefront context of a compute unit and turns a software wait request into an issue stall. Each time the pipeline sends a scalar memory load, the counter of the issuing wavefront goes up. Each time a load result comes back, the counter of the owning wavefront goes down.

A wait request names a wavefront and a threshold N. From the next cycle on, that wavefront's bit in the issue-enable vector stays low for as long as its counter is above N. The bit rises as soon as the counter drops to N or below, and the pending wait is then dropped. Software sets N, so it decides how many loads may still be in flight before the wavefront continues. There is no per-register busy scoreboard.

The counters saturate at their maximum, and a return to an empty counter is discarded. Both cases raise a one-cycle error pulse.

Top module: `wf_load_gate`

## Requirements
- R1: A load-issue strobe adds one to the outstanding count of the wavefront named on `ld_issue_wf`.
- R2: A load-return strobe takes one from the outstanding count of the wavefront named on `ld_ret_wf`.
- R3: In the cycle after a wait request for wavefront w with threshold N, `issue_en[w]` is 0 if w's count is then above N, and it stays 0 while the count stays above N.
- R4: `issue_en[w]` returns to 1 in the same cycle that w's count first becomes less than or equal to N, and the wait is then cleared. Later load issues do not stall w again until a new wait request arrives. A new request for a wavefront that is already waiting replaces its threshold.
- R5: An issue and a return for the same wavefront in the same cycle leave its count unchanged and raise no error. An issue and a return for different wavefronts in the same cycle are both applied.
- R6: Counts are 4 bits wide and saturate at 15. An issue without a matching return at count 15 keeps the count at 15 and drives `ovf_err` high for exactly the cycle after that edge.
- R7: A return without a matching issue at count 0 is ignored: the count stays 0 and `udf_err` is high for exactly the cycle after that edge.
- R8: Reset clears every count and every pending wait. After reset `issue_en` is all ones (8'hFF) and both error flags are 0.
- R9: The block holds 8 wavefront contexts. Each context changes only in response to strobes and waits that carry its own ID, with wavefront 0 on bit 0 of `issue_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_issue_vld | input | 1 | A scalar load was issued this cycle |
| ld_issue_wf | input | 3 | Wavefront that issued the load |
| ld_ret_vld | input | 1 | A scalar load returned this cycle |
| ld_ret_wf | input | 3 | Wavefront that owns the returned load |
| wait_vld | input | 1 | Wait request this cycle |
| wait_wf | input | 3 | Wavefront executing the wait |
| wait_thr | input | 4 | Largest outstanding count allowed to continue |
| issue_en | output | 8 | Per-wavefront issue permission, bit w for wavefront w |
| ovf_err | output | 1 | Pulse: increment at a saturated count |
| udf_err | output | 1 | Pulse: return at a zero count |

## Verification
The counters have no port of their own. A wrong count only shows up when a wait is later asked of that wavefront: the stall either lasts too long, ends too early, or never happens. The bench therefore reads each count back by sending wait pairs with thresholds c-1 and c, which reveals the count one cycle after the request. A wrong pending flag shows up as `issue_en` in the very next cycle, so the bench compares the whole vector after every cycle, and it checks the error pulses in the cycle after each edge.

// File: rtl/wfl_pkg.sv
package wfl_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_op_e;

   function automatic cnt_op_e pick_op(input logic up, input logic down);
      if (up && !down)      return CNT_UP;
      else if (down && !up) return CNT_DOWN;
      else                  return CNT_HOLD;
   endfunction

endpackage

// File: rtl/wfl_counter.sv
module wfl_counter
   import wfl_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter bit ERR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic             udf
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   cnt_op_e          op;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ovf_c, udf_c;

   always_comb begin
      op    = pick_op(inc, dec);
      ovf_c = (op == CNT_UP)   && (cnt_q == MAXV);
      udf_c = (op == CNT_DOWN) && (cnt_q == '0);
      cnt_d = cnt_q;
      if (op == CNT_UP && !ovf_c)   cnt_d = cnt_q + 1'b1;
      if (op == CNT_DOWN && !udf_c) cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

   generate
      if (ERR_REG) begin : g_err_reg
         logic ovf_q, udf_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ovf_q <= 1'b0;
               udf_q <= 1'b0;
            end else begin
               ovf_q <= ovf_c;
               udf_q <= udf_c;
            end
         end
         assign ovf = ovf_q;
         assign udf = udf_q;
      end else begin : g_err_comb
         assign ovf = ovf_c;
         assign udf = udf_c;
      end
   endgenerate

   assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(cnt_q));
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt_q == MAXV) |=> cnt_q == MAXV);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/wfl_wait_gate.sv
module wfl_wait_gate #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wait_req,
   input  logic [CNT_W-1:0] wait_lim,
   input  logic [CNT_W-1:0] cnt,
   output logic             issue_ok
);
   logic             pend_q;
   logic [CNT_W-1:0] lim_q;
   logic             over;

   assign over     = cnt > lim_q;
   assign issue_ok = !(pend_q && over);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         lim_q  <= '0;
      end else if (wait_req) begin
         pend_q <= 1'b1;
         lim_q  <= wait_lim;
      end else if (pend_q && !over) begin
         pend_q <= 1'b0;
      end
   end

   // a stall can only begin right after a wait request
   assert_stall_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(issue_ok) |-> $past(wait_req));
   // with no wait pending and none arriving, the next cycle may issue
   assert_free_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !wait_req) |=> issue_ok);
endmodule

// File: rtl/wf_load_gate.sv
module wf_load_gate #(
   parameter int NUM_WF  = 8,
   parameter int CNT_W   = 4,
   parameter bit ERR_REG = 1'b1,
   localparam int WF_W   = $clog2(NUM_WF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_issue_vld,
   input  logic [WF_W-1:0]   ld_issue_wf,
   input  logic              ld_ret_vld,
   input  logic [WF_W-1:0]   ld_ret_wf,
   input  logic              wait_vld,
   input  logic [WF_W-1:0]   wait_wf,
   input  logic [CNT_W-1:0]  wait_thr,
   output logic [NUM_WF-1:0] issue_en,
   output logic              ovf_err,
   output logic              udf_err
);
   generate
      if (NUM_WF < 2) begin : g_bad_wf
         $error("wf_load_gate: NUM_WF must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wf_load_gate: CNT_W must be at least 1");
      end
   endgenerate

   logic [NUM_WF-1:0] ovf_v, udf_v;

   generate
      for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
         logic             inc_w, dec_w, wait_w;
         logic [CNT_W-1:0] cnt_w;

         assign inc_w  = ld_issue_vld && (ld_issue_wf == WF_W'(w));
         assign dec_w  = ld_ret_vld   && (ld_ret_wf   == WF_W'(w));
         assign wait_w = wait_vld     && (wait_wf     == WF_W'(w));

         wfl_counter #(.CNT_W(CNT_W), .ERR_REG(ERR_REG)) u_cnt (
            .clk (clk),
            .rst_n (rst_n),
            .inc (inc_w),
            .dec (dec_w),
            .cnt (cnt_w),
            .ovf (ovf_v[w]),
            .udf (udf_v[w])
         );

         wfl_wait_gate #(.CNT_W(CNT_W)) u_gate (
            .clk (clk),
            .rst_n (rst_n),
            .wait_req (wait_w),
            .wait_lim (wait_thr),
            .cnt (cnt_w),
            .issue_ok (issue_en[w])
         );
      end
   endgenerate

   assign ovf_err = |ovf_v;
   assign udf_err = |udf_v;

   // at most one strobe of each kind per cycle, so at most one slice flags
   assert_single_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovf_v));
   assert_single_udf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(udf_v));
   // an idle cycle with no wait request never lowers any issue bit
   assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_vld) |=> ($past(issue_en) & ~issue_en) == '0);
endmodule

// File: tb/wf_load_gate_test.sv
module wf_load_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int NWF  = 8;
   localparam int CW   = 4;
   localparam int WW   = 3;
   localparam int MAXC = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_issue_vld = 1'b0, ld_ret_vld = 1'b0, wait_vld = 1'b0;
   logic [WW-1:0] ld_issue_wf = '0, ld_ret_wf = '0, wait_wf = '0;
   logic [CW-1:0] wait_thr = '0;
   logic [NWF-1:0] issue_en;
   logic ovf_err, udf_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   wf_load_gate uut (
      .clk (clk), .rst_n (rst_n),
      .ld_issue_vld (ld_issue_vld), .ld_issue_wf (ld_issue_wf),
      .ld_ret_vld (ld_ret_vld), .ld_ret_wf (ld_ret_wf),
      .wait_vld (wait_vld), .wait_wf (wait_wf), .wait_thr (wait_thr),
      .issue_en (issue_en), .ovf_err (ovf_err), .udf_err (udf_err)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cnt_m [NWF];
   bit pend_m[NWF];
   int thr_m [NWF];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, check at the next negedge
   task automatic cyc(input bit iv, input int iw, input bit rv, input int rw,
                      input bit wv, input int ww, input int wt);
      bit e_ovf = 0;
      bit e_udf = 0;
      logic [NWF-1:0] e_en;
      ld_issue_vld = iv; ld_issue_wf = WW'(iw);
      ld_ret_vld = rv;   ld_ret_wf = WW'(rw);
      wait_vld = wv;     wait_wf = WW'(ww); wait_thr = CW'(wt);
      for (int w = 0; w < NWF; w++) begin
         bit inc = iv && iw == w;
         bit dec = rv && rw == w;
         int old = cnt_m[w];
         if (wv && ww == w) begin
            pend_m[w] = 1; thr_m[w] = wt;
         end else if (pend_m[w] && old <= thr_m[w]) begin
            pend_m[w] = 0;
         end
         if (inc && !dec) begin
            if (old == MAXC) e_ovf = 1; else cnt_m[w] = old + 1;
         end
         if (dec && !inc) begin
            if (old == 0) e_udf = 1; else cnt_m[w] = old - 1;
         end
      end
      @(negedge clk);
      ld_issue_vld = 0; ld_ret_vld = 0; wait_vld = 0;
      for (int w = 0; w < NWF; w++)
         e_en[w] = !(pend_m[w] && cnt_m[w] > thr_m[w]);
      chk(issue_en === e_en, "R3", "issue_en vector", int'(issue_en), int'(e_en));
      chk(ovf_err === e_ovf, "R6", "ovf_err", int'(ovf_err), int'(e_ovf));
      chk(udf_err === e_udf, "R7", "udf_err", int'(udf_err), int'(e_udf));
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic issue(input int w);
      cyc(1, w, 0, 0, 0, 0, 0);
   endtask

   task automatic ret(input int w);
      cyc(0, 0, 1, w, 0, 0, 0);
   endtask

   // read a count back through wait thresholds exp-1 and exp
   task automatic probe(input int w, input int exp, input string req);
      if (exp > 0) begin
         cyc(0, 0, 0, 0, 1, w, exp - 1);
         chk(issue_en[w] == 1'b0, req, "count above exp-1 stalls", int'(issue_en[w]), 0);
      end
      cyc(0, 0, 0, 0, 1, w, exp);
      chk(issue_en[w] == 1'b1, req, "count at or below exp frees", int'(issue_en[w]), 1);
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < NWF; w++) begin
         cnt_m[w] = 0; pend_m[w] = 0; thr_m[w] = 0;
      end
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(issue_en === 8'hFF, "R8", "issue_en after reset", int'(issue_en), 255);
      chk(ovf_err === 1'b0 && udf_err === 1'b0, "R8", "error flags after reset",
          int'({ovf_err, udf_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int w = 0; w < NWF; w++) probe(w, 0, "R8");

      // R1, R9: distinct counts per wavefront, then read all back
      for (int w = 0; w < NWF; w++)
         for (int k = 0; k <= w; k++) issue(w);
      for (int w = 0; w < NWF; w++) probe(w, w + 1, "R9");

      // R2: returns lower the count
      ret(4); ret(4);
      probe(4, 3, "R2");

      // R3/R4: wait for zero on wavefront 2 (count 3)
      cyc(0, 0, 0, 0, 1, 2, 0);
      chk(issue_en[2] == 1'b0, "R3", "wait for zero stalls", int'(issue_en[2]), 0);
      chk(issue_en[1] == 1'b1, "R9", "other wavefront unaffected", int'(issue_en[1]), 1);
      ret(2);
      chk(issue_en[2] == 1'b0, "R3", "still stalled at 2", int'(issue_en[2]), 0);
      ret(2);
      ret(2);
      chk(issue_en[2] == 1'b1, "R4", "released at zero", int'(issue_en[2]), 1);
      issue(2); issue(2);
      chk(issue_en[2] == 1'b1, "R4", "no re-stall after release", int'(issue_en[2]), 1);

      // R3/R4: nonzero threshold on wavefront 5 (count 6), then replace it
      cyc(0, 0, 0, 0, 1, 5, 4);
      chk(issue_en[5] == 1'b0, "R3", "count 6 over 4 stalls", int'(issue_en[5]), 0);
      ret(5);
      chk(issue_en[5] == 1'b0, "R3", "count 5 over 4 stalls", int'(issue_en[5]), 0);
      cyc(0, 0, 0, 0, 1, 5, 5);
      chk(issue_en[5] == 1'b1, "R4", "new threshold 5 frees", int'(issue_en[5]), 1);
      idle();

      // R5: paired issue/return on the same and on different wavefronts
      cyc(1, 3, 1, 3, 0, 0, 0);
      probe(3, 4, "R5");
      cyc(1, 0, 1, 0, 0, 0, 0);
      cyc(1, 0, 1, 0, 0, 0, 0);
      probe(0, 1, "R5");
      cyc(1, 6, 1, 1, 0, 0, 0);
      probe(6, 8, "R5");
      probe(1, 1, "R5");

      // R6: fill wavefront 7 (count 8) to saturation and push past it
      while (cnt_m[7] < MAXC) issue(7);
      issue(7);
      chk(ovf_err == 1'b1, "R6", "overflow pulse", int'(ovf_err), 1);
      idle();
      chk(ovf_err == 1'b0, "R6", "overflow pulse lasts one cycle", int'(ovf_err), 0);
      probe(7, MAXC, "R6");

      // R7: drain wavefront 0 and return once more
      ret(0);
      ret(0);
      chk(udf_err == 1'b1, "R7", "underflow pulse", int'(udf_err), 1);
      probe(0, 0, "R7");
      cyc(1, 0, 0, 0, 0, 0, 0);
      probe(0, 1, "R7");

      // sweep: every wavefront back to zero, reading each back
      for (int w = 0; w < NWF; w++) begin
         while (cnt_m[w] > 0) ret(w);
         probe(w, 0, "R2");
      end

      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule